// File: doc/BRIEF.md
# Test Schedule Sequencer

This block steps through a fixed schedule of test transfers on a shared bus that carries test data for several cores. Each schedule entry names one target core, the number of consecutive test packages that go to it in one transfer, and the earliest cycle at which that transfer may be launched. The schedule is given as parameter tables.

When a transfer is launched, the sequencer raises a one-hot select to the target core. It raises an identical one-hot select to the test source, which uses it to put the packages on the bus. The sequencer then holds both selects until the target core answers with its ready line. After that it moves to the next entry.

Entries are always launched in table order, and only one transfer is ever open. A start pulse runs the whole schedule from entry 0. A done flag marks that the last transfer has been acknowledged. Two sticky flags report problems: a ready line raised by a core that is not selected, and a transfer that has waited too long for its ready.

Top module: `tsq_sequencer`

## Requirements
- R1: After reset, all selects are low, the package count is 0, and busy, done and both error flags are 0.
- R2: A start pulse in the idle or done state launches the schedule at entry 0, clears done and both error flags, and restarts the cycle count at 0. A start pulse while busy has no effect on the entry index or on the timing.
- R3: Clock edges are numbered 1, 2, ... after the edge that accepts start. An entry with earliest time T is first visible on the selects after edge max(T+1, a+1). Here a is the edge that accepted the previous entry's ready, or 0 for the first entry.
- R4: While a transfer is open, core_sel_o has only bit c set, where c is the entry's core index. src_sel_o equals core_sel_o, and pkt_cnt_o equals the entry's package count. When no transfer is open, both selects and pkt_cnt_o are 0.
- R5: An open transfer keeps its select until the selected core's ready bit is seen at an edge. The select is 0 after that edge, so at most one transfer is open and consecutive transfers are separated by at least one cycle.
- R6: Entries are issued in table order 0, 1, ... N_ENT-1, and entry_o shows the index of the current entry.
- R7: After the edge that accepts the last entry's ready, done_o is 1 and busy_o is 0. Done stays 1 with all selects low until the next start.
- R8: A ready bit from any core that is not currently selected causes no advance and sets proto_err_o, which stays set until the next accepted start.
- R9: Suppose a select becomes visible after edge s and no ready is accepted at edges s+1 through s+TMO_CYC. Then tmo_err_o is 1 after edge s+TMO_CYC. The transfer keeps waiting, and the flag stays set until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch the schedule from entry 0 |
| core_rdy_i | input | N_CORES | Ready/received reply, one bit per core |
| core_sel_o | output | N_CORES | One-hot select to the target core |
| src_sel_o | output | N_CORES | Same select, driven to the test source |
| pkt_cnt_o | output | PKT_W | Package count of the open transfer |
| entry_o | output | ENT_W | Current schedule entry index |
| busy_o | output | 1 | Schedule in progress |
| done_o | output | 1 | Last entry acknowledged |
| proto_err_o | output | 1 | Sticky: ready from a non-selected core |
| tmo_err_o | output | 1 | Sticky: ready not received in time |

## Verification
The assertions assume that start_i and core_rdy_i change only between clock edges and are low during reset. They also assume that no accepted start coincides with a ready pulse, because the start clears the error flag that the ready would otherwise set. The bench drives every input at the falling edge. It raises each ready for exactly one cycle after a chosen hold time. It pulses start only while idle, or deliberately in a waiting state with every ready low. The bench runs the whole schedule three times with different hold-time vectors, one of which goes past the timeout window.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2,
        ST_DONE = 2'd3
    } tsq_state_e;

endpackage

// File: rtl/tsq_entry_mux.sv
module tsq_entry_mux #(
    parameter int N_ENT  = 5,
    parameter int ENT_W  = 3,
    parameter int CORE_W = 2,
    parameter int PKT_W  = 4,
    parameter int TIME_W = 12,
    parameter logic [N_ENT*CORE_W-1:0] TBL_CORE = '0,
    parameter logic [N_ENT*PKT_W-1:0]  TBL_PKT  = '0,
    parameter logic [N_ENT*TIME_W-1:0] TBL_TIME = '0
) (
    input  logic [ENT_W-1:0]  idx_i,
    output logic [CORE_W-1:0] core_o,
    output logic [PKT_W-1:0]  pkt_o,
    output logic [TIME_W-1:0] time_o
);

    logic [CORE_W-1:0] core_a [N_ENT];
    logic [PKT_W-1:0]  pkt_a  [N_ENT];
    logic [TIME_W-1:0] time_a [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        assign core_a[g] = TBL_CORE[g*CORE_W +: CORE_W];
        assign pkt_a[g]  = TBL_PKT[g*PKT_W +: PKT_W];
        assign time_a[g] = TBL_TIME[g*TIME_W +: TIME_W];
    end

    always_comb begin
        core_o = '0;
        pkt_o  = '0;
        time_o = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (idx_i == ENT_W'(i)) begin
                core_o = core_a[i];
                pkt_o  = pkt_a[i];
                time_o = time_a[i];
            end
        end
    end

endmodule

// File: rtl/tsq_send_clock.sv
module tsq_send_clock #(
    parameter int TIME_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [TIME_W-1:0] limit_i,
    output logic              reached_o
);

    logic [TIME_W-1:0] cyc_d, cyc_q;

    always_comb begin
        if (clr_i) begin
            cyc_d = '0;
        end else if (cyc_q == {TIME_W{1'b1}}) begin
            cyc_d = cyc_q;
        end else begin
            cyc_d = cyc_q + TIME_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_d;
    end

    assign reached_o = (cyc_q >= limit_i);

endmodule

// File: rtl/tsq_hold_timer.sv
module tsq_hold_timer #(
    parameter int TMO_CYC = 20,
    parameter int TMO_W   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic hit_o
);

    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q == TMO_W'(TMO_CYC)) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + TMO_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit_o = run_i && (cnt_q == TMO_W'(TMO_CYC - 1));

endmodule

// File: rtl/tsq_onehot.sv
module tsq_onehot #(
    parameter int N_CORES = 4,
    parameter int CORE_W  = 2
) (
    input  logic               en_i,
    input  logic [CORE_W-1:0]  idx_i,
    output logic [N_CORES-1:0] vec_o
);

    for (genvar g = 0; g < N_CORES; g++) begin : g_bit
        assign vec_o[g] = en_i && (idx_i == CORE_W'(g));
    end

endmodule

// File: rtl/tsq_sequencer.sv
module tsq_sequencer #(
    parameter int N_CORES = 4,
    parameter int N_ENT   = 5,
    parameter int PKT_W   = 4,
    parameter int TIME_W  = 12,
    parameter int TMO_CYC = 20,
    parameter int CORE_W  = $clog2(N_CORES),
    parameter int ENT_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    parameter logic [N_ENT*CORE_W-1:0] TBL_CORE = {2'd1, 2'd2, 2'd0, 2'd3, 2'd1},
    parameter logic [N_ENT*PKT_W-1:0]  TBL_PKT  = {4'd1, 4'd5, 4'd2, 4'd1, 4'd3},
    parameter logic [N_ENT*TIME_W-1:0] TBL_TIME = {12'd60, 12'd31, 12'd30, 12'd6, 12'd4}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [N_CORES-1:0] core_rdy_i,
    output logic [N_CORES-1:0] core_sel_o,
    output logic [N_CORES-1:0] src_sel_o,
    output logic [PKT_W-1:0]   pkt_cnt_o,
    output logic [ENT_W-1:0]   entry_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               proto_err_o,
    output logic               tmo_err_o
);
    import tsq_pkg::*;

    localparam int TMO_W = $clog2(TMO_CYC + 1);
    localparam logic [ENT_W-1:0] LAST_ENT = ENT_W'(N_ENT - 1);

    typedef struct packed {
        tsq_state_e       state;
        logic [ENT_W-1:0] entry;
        logic             done;
        logic             perr;
        logic             terr;
    } seq_reg_t;

    seq_reg_t cur_q, nxt_d;

    logic [CORE_W-1:0]  ent_core;
    logic [PKT_W-1:0]   ent_pkt;
    logic [TIME_W-1:0]  ent_time;
    logic [N_CORES-1:0] sel_vec;
    logic               sending;
    logic               own_rdy;
    logic               foreign_rdy;
    logic               launch;
    logic               time_ok;
    logic               tmo_hit;
    logic               hold_run;

    tsq_entry_mux #(
        .N_ENT    (N_ENT),
        .ENT_W    (ENT_W),
        .CORE_W   (CORE_W),
        .PKT_W    (PKT_W),
        .TIME_W   (TIME_W),
        .TBL_CORE (TBL_CORE),
        .TBL_PKT  (TBL_PKT),
        .TBL_TIME (TBL_TIME)
    ) u_entry (
        .idx_i  (cur_q.entry),
        .core_o (ent_core),
        .pkt_o  (ent_pkt),
        .time_o (ent_time)
    );

    assign sending = (cur_q.state == ST_SEND);

    tsq_onehot #(
        .N_CORES (N_CORES),
        .CORE_W  (CORE_W)
    ) u_dec (
        .en_i  (sending),
        .idx_i (ent_core),
        .vec_o (sel_vec)
    );

    assign own_rdy     = |(core_rdy_i & sel_vec);
    assign foreign_rdy = |(core_rdy_i & ~sel_vec);
    assign launch      = start_i && ((cur_q.state == ST_IDLE) || (cur_q.state == ST_DONE));
    assign hold_run    = sending && !own_rdy;

    tsq_send_clock #(
        .TIME_W (TIME_W)
    ) u_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (launch),
        .limit_i   (ent_time),
        .reached_o (time_ok)
    );

    tsq_hold_timer #(
        .TMO_CYC (TMO_CYC),
        .TMO_W   (TMO_W)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (hold_run),
        .hit_o (tmo_hit)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            ST_IDLE, ST_DONE: begin
                if (launch) begin
                    nxt_d.state = ST_WAIT;
                    nxt_d.entry = '0;
                    nxt_d.done  = 1'b0;
                    nxt_d.perr  = 1'b0;
                    nxt_d.terr  = 1'b0;
                end else if (foreign_rdy) begin
                    nxt_d.perr = 1'b1;
                end
            end
            ST_WAIT: begin
                if (foreign_rdy) nxt_d.perr = 1'b1;
                if (time_ok)     nxt_d.state = ST_SEND;
            end
            ST_SEND: begin
                if (foreign_rdy) nxt_d.perr = 1'b1;
                if (own_rdy) begin
                    if (cur_q.entry == LAST_ENT) begin
                        nxt_d.state = ST_DONE;
                        nxt_d.done  = 1'b1;
                    end else begin
                        nxt_d.state = ST_WAIT;
                        nxt_d.entry = cur_q.entry + ENT_W'(1);
                    end
                end else if (tmo_hit) begin
                    nxt_d.terr = 1'b1;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, entry: '0, done: 1'b0, perr: 1'b0, terr: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign core_sel_o  = sel_vec;
    assign src_sel_o   = sel_vec;
    assign pkt_cnt_o   = sending ? ent_pkt : '0;
    assign entry_o     = cur_q.entry;
    assign busy_o      = (cur_q.state == ST_WAIT) || sending;
    assign done_o      = cur_q.done;
    assign proto_err_o = cur_q.perr;
    assign tmo_err_o   = cur_q.terr;

endmodule

// File: rtl/tsq_sequencer_chk.sv
module tsq_sequencer_chk #(
    parameter int N_CORES = 4,
    parameter int PKT_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [N_CORES-1:0] core_rdy_i,
    input logic [N_CORES-1:0] core_sel_o,
    input logic [N_CORES-1:0] src_sel_o,
    input logic [PKT_W-1:0]   pkt_cnt_o,
    input logic               done_o,
    input logic               proto_err_o
);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_sel_o)); // R4

    AST_SRC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel_o == core_sel_o); // R4

    AST_PKT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (core_sel_o == '0) |-> (pkt_cnt_o == '0)); // R4

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_sel_o != '0) && !(|(core_rdy_i & core_sel_o)))
        |=> (core_sel_o == $past(core_sel_o))); // R5

    AST_SEL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (|(core_rdy_i & core_sel_o)) |=> (core_sel_o == '0)); // R5

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (core_sel_o == '0)); // R7

    AST_DONE_STICK: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R7

    AST_FOREIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(core_rdy_i & ~core_sel_o)) && !start_i) |=> proto_err_o); // R8

endmodule

bind tsq_sequencer tsq_sequencer_chk #(
    .N_CORES (N_CORES),
    .PKT_W   (PKT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .core_rdy_i  (core_rdy_i),
    .core_sel_o  (core_sel_o),
    .src_sel_o   (src_sel_o),
    .pkt_cnt_o   (pkt_cnt_o),
    .done_o      (done_o),
    .proto_err_o (proto_err_o)
);

// File: tb/test_tsq_sequencer.sv
module test_tsq_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int NC   = 4;
    localparam int NE   = 5;
    localparam int TMO  = 20;
    localparam logic [NE*2-1:0]  B_CORE = {2'd1, 2'd2, 2'd0, 2'd3, 2'd1};
    localparam logic [NE*4-1:0]  B_PKT  = {4'd1, 4'd5, 4'd2, 4'd1, 4'd3};
    localparam logic [NE*12-1:0] B_TIME = {12'd60, 12'd31, 12'd30, 12'd6, 12'd4};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NC-1:0] rdy = '0;
    logic [NC-1:0] sel, src;
    logic [3:0]    pkt;
    logic [2:0]    ent;
    logic          busy, done, perr, terr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsq_sequencer #(
        .N_CORES (NC), .N_ENT (NE), .PKT_W (4), .TIME_W (12), .TMO_CYC (TMO),
        .TBL_CORE (B_CORE), .TBL_PKT (B_PKT), .TBL_TIME (B_TIME)
    ) i_tsq_sequencer (
        .clk (clk), .rst_n (rst_n), .start_i (start), .core_rdy_i (rdy),
        .core_sel_o (sel), .src_sel_o (src), .pkt_cnt_o (pkt), .entry_o (ent),
        .busy_o (busy), .done_o (done), .proto_err_o (perr), .tmo_err_o (terr)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    function automatic int e_core(input int e); return int'(B_CORE[e*2 +: 2]); endfunction
    function automatic int e_pkt(input int e);  return int'(B_PKT[e*4 +: 4]);  endfunction
    function automatic int e_time(input int e); return int'(B_TIME[e*12 +: 12]); endfunction

    task automatic run_sched(input int dly [NE], input bit inject);
        int  w = 0;
        bit  tseen = 1'b0;
        start = 1'b1;
        tick();
        start = 1'b0;
        cyc = 0;
        chk(done == 0, "R2 done cleared", done, 0);
        chk(perr == 0, "R2 proto flag cleared", perr, 0);
        chk(terr == 0, "R2 timeout flag cleared", terr, 0);
        chk(busy == 1 && ent == 0, "R2 launch at entry 0", ent, 0);
        for (int e = 0; e < NE; e++) begin
            int c = e_core(e);
            int t_exp = (e_time(e) > w) ? e_time(e) + 1 : w + 1;
            int guard = 0;
            while (sel == '0 && guard < 500) begin
                if (inject && e == 2 && cyc == 15) begin
                    start = 1'b1;
                    tick();
                    start = 1'b0;
                    chk(ent == 3'(e) && busy == 1, "R2 start while busy ignored", ent, e);
                end else begin
                    tick();
                end
                guard++;
            end
            chk(cyc == t_exp, "R3 launch edge", cyc, t_exp);
            chk(sel == NC'(1 << c), "R4 core select", sel, 1 << c);
            chk(src == NC'(1 << c), "R4 source select", src, 1 << c);
            chk(pkt == 4'(e_pkt(e)), "R4 package count", pkt, e_pkt(e));
            chk(ent == 3'(e), "R6 entry order", ent, e);
            for (int k = 1; k <= dly[e]; k++) begin
                bit inj = inject && e == 2 && k == 2;
                if (inj) rdy = NC'(1 << ((c + 1) % NC));
                tick();
                rdy = '0;
                chk(sel == NC'(1 << c), "R5 select held", sel, 1 << c);
                if (inj) chk(perr == 1, "R8 foreign ready flagged", perr, 1);
                if (k >= TMO) tseen = 1'b1;
                chk(terr == tseen, "R9 timeout flag", terr, tseen);
            end
            rdy = NC'(1 << c);
            tick();
            rdy = '0;
            w = cyc;
            chk(sel == '0 && pkt == 0, "R5 select dropped", sel, 0);
            if (e < NE - 1) begin
                chk(ent == 3'(e + 1), "R6 next entry", ent, e + 1);
                chk(done == 0, "R7 not yet done", done, 0);
            end else begin
                chk(done == 1 && busy == 0, "R7 done after last ready", done, 1);
            end
        end
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(done == 1 && sel == '0, "R7 done persists", done, 1);
        end
        chk(perr == inject, "R8 proto flag state", perr, inject);
        chk(terr == tseen, "R9 final timeout flag", terr, tseen);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog expired", cyc, 0);
        if (!finished) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sel == '0 && src == '0, "R1 selects low", sel, 0);
        chk(pkt == 0, "R1 package count", pkt, 0);
        chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
        chk(perr == 0 && terr == 0, "R1 error flags", {perr, terr}, 0);
        rst_n = 1'b1;
        repeat (2) tick();
        chk(sel == '0 && busy == 0, "R1 idle after reset", sel, 0);
        run_sched('{2, 0, 5, 1, 3}, 1'b1);
        run_sched('{0, 0, 0, 0, 0}, 1'b0);
        run_sched('{23, 1, 0, 7, 2}, 1'b0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule